// File: doc/BRIEF.md
# Secure Mode and Memory Region Guard

This block tracks which trust level the processor is running at and judges every memory access against five programmable address regions. Three modes exist: standard (untrusted), secure, and suspended secure. Secure code can drop into suspended mode to run untrusted helpers such as input/output routines inside the same process. While suspended, those helpers cannot touch any protected region, and they can only return to secure execution at the program counter recorded when the suspend happened.

Each region has an inclusive base and limit. Two regions are static (read-only): one integrity-verified, one verified and encrypted. Two are dynamic (read-write) with the same two protection levels. The fifth is unprotected. For every access the block returns a grant or a fault one cycle later. It also returns the matched region code and two flags that tell downstream memory logic whether to run integrity checking and whether to encrypt or decrypt. Entry into secure mode waits for an external kernel-hash unit to report completion. Hashing and cryptography themselves lie outside the block.

Top module: `trust_region_guard`

## Requirements
- R1: After reset, the mode is standard (code 0), busy is low, no fault or access result is pending, and every region is empty, so any access faults with region code 7.
- R2: A command with op 0 (enter) in standard mode sets busy on the next cycle. The mode becomes secure (code 1) on the cycle after hash_done_i is sampled high while busy is set, and busy clears at the same time. Commands are ignored while busy. Enter in any other mode raises cmd_fault_o.
- R3: Op 3 (exit) in secure or suspended mode returns the mode to standard. Exit in standard mode raises cmd_fault_o.
- R4: Op 1 (suspend) in secure mode moves the mode to suspended (code 2) and records pc_i as the resume point. Suspend in any other mode raises cmd_fault_o.
- R5: Op 2 (resume) in suspended mode returns to secure only when pc_i equals the recorded resume point. On a mismatch, or in any other mode, cmd_fault_o rises and the mode is unchanged.
- R6: Writes to region 0 (static verified) or region 1 (static verified+encrypted) fault in every mode.
- R7: In standard and suspended modes, only accesses whose region is 4 (unprotected) are granted.
- R8: A granted access to regions 0–3 sets acc_integ_o. A granted access to region 1 or 3 also sets acc_crypt_o. A fault clears both flags.
- R9: Each sampled acc_valid_i produces, on the following cycle, acc_done_o together with exactly one of acc_grant_o and acc_fault_o. Both are low when acc_done_o is low.
- R10: When regions overlap, the lowest region code containing the address is reported and judged. An address in no region faults with code 7.
- R11: A configuration write sets the inclusive base and limit of region cfg_sel_i (0–4). It is accepted only in secure mode and is ignored otherwise, or when the select is above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Mode command strobe |
| cmd_op_i | input | 2 | 0 enter, 1 suspend, 2 resume, 3 exit |
| pc_i | input | PC_W | Program counter at the command |
| hash_done_i | input | 1 | Kernel hash finished |
| cfg_we_i | input | 1 | Region bound write strobe |
| cfg_sel_i | input | 3 | Region code to write |
| cfg_base_i | input | ADDR_W | Inclusive lower bound |
| cfg_limit_i | input | ADDR_W | Inclusive upper bound |
| acc_valid_i | input | 1 | Access request strobe |
| acc_addr_i | input | ADDR_W | Access address |
| acc_write_i | input | 1 | 1 write, 0 read |
| mode_o | output | 2 | Current mode code |
| busy_o | output | 1 | Waiting for kernel hash |
| cmd_fault_o | output | 1 | Previous command rejected |
| acc_done_o | output | 1 | Access result valid |
| acc_grant_o | output | 1 | Access allowed |
| acc_fault_o | output | 1 | Access denied |
| acc_integ_o | output | 1 | Apply integrity checking |
| acc_crypt_o | output | 1 | Apply encryption/decryption |
| acc_region_o | output | 3 | Matched region code, 7 for none |

## Verification
Several properties are checked on every cycle. The mode never takes code 3. The only way from standard to secure is a hash completion while busy. Suspended-to-secure and secure-to-suspended moves each follow their own command. Grant and fault are exclusive and track done. The crypt flag implies a granted integrity access. Static-region writes fault, untrusted modes are granted only unprotected accesses, and a miss faults. The bench's scenarios are needed to show the rest: the resume point is compared against the program counter captured at suspend, lowest-code priority holds among overlapping bounds, configuration writes are dropped outside secure mode, and commands are ignored while the hash is pending.

// File: rtl/trg_pkg.sv
`timescale 1ns/1ps
package trg_pkg;
   typedef enum logic [1:0] {
      MODE_STD  = 2'd0,
      MODE_SEC  = 2'd1,
      MODE_SUSP = 2'd2
   } mode_e;

   typedef enum logic [1:0] {
      OP_ENTER   = 2'd0,
      OP_SUSPEND = 2'd1,
      OP_RESUME  = 2'd2,
      OP_EXIT    = 2'd3
   } op_e;

   localparam int          NUM_REGIONS = 5;
   localparam logic [2:0]  RG_STAT_VER = 3'd0;
   localparam logic [2:0]  RG_STAT_ENC = 3'd1;
   localparam logic [2:0]  RG_DYN_VER  = 3'd2;
   localparam logic [2:0]  RG_DYN_ENC  = 3'd3;
   localparam logic [2:0]  RG_OPEN     = 3'd4;
   localparam logic [2:0]  RG_NONE     = 3'd7;

   function automatic logic rg_is_static(input logic [2:0] rg);
      return (rg == RG_STAT_VER) || (rg == RG_STAT_ENC);
   endfunction

   function automatic logic rg_is_verified(input logic [2:0] rg);
      return rg < RG_OPEN;
   endfunction

   function automatic logic rg_is_encrypted(input logic [2:0] rg);
      return (rg == RG_STAT_ENC) || (rg == RG_DYN_ENC);
   endfunction
endpackage

// File: rtl/trg_region_bank.sv
`timescale 1ns/1ps
module trg_region_bank #(
   parameter int ADDR_W = 32,
   parameter int NREG   = 5,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [NREG-1:0]   hit_vec
);
   localparam logic [ADDR_W-1:0] EMPTY_BASE  = '1;
   localparam logic [ADDR_W-1:0] EMPTY_LIMIT = '0;

   for (genvar g = 0; g < NREG; g++) begin : g_region
      logic [ADDR_W-1:0] base_q;
      logic [ADDR_W-1:0] limit_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q  <= EMPTY_BASE;
            limit_q <= EMPTY_LIMIT;
         end else if (wr_en && (wr_sel == SEL_W'(g))) begin
            base_q  <= wr_base;
            limit_q <= wr_limit;
         end
      end

      assign hit_vec[g] = (probe_addr >= base_q) && (probe_addr <= limit_q);
   end
endmodule

// File: rtl/trg_mode_fsm.sv
`timescale 1ns/1ps
module trg_mode_fsm
   import trg_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [1:0]      cmd_op,
   input  logic [PC_W-1:0] pc,
   input  logic            hash_done,
   output mode_e           mode,
   output logic            busy,
   output logic            cmd_fault
);
   logic [PC_W-1:0] resume_q;
   op_e             op;

   assign op = op_e'(cmd_op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= MODE_STD;
         busy      <= 1'b0;
         cmd_fault <= 1'b0;
         resume_q  <= '0;
      end else begin
         cmd_fault <= 1'b0;
         if (busy) begin
            if (hash_done) begin
               mode <= MODE_SEC;
               busy <= 1'b0;
            end
         end else if (cmd_valid) begin
            unique case (op)
               OP_ENTER: begin
                  if (mode == MODE_STD) busy <= 1'b1;
                  else                  cmd_fault <= 1'b1;
               end
               OP_SUSPEND: begin
                  if (mode == MODE_SEC) begin
                     mode     <= MODE_SUSP;
                     resume_q <= pc;
                  end else begin
                     cmd_fault <= 1'b1;
                  end
               end
               OP_RESUME: begin
                  if ((mode == MODE_SUSP) && (pc == resume_q)) mode <= MODE_SEC;
                  else                                          cmd_fault <= 1'b1;
               end
               OP_EXIT: begin
                  if (mode != MODE_STD) mode <= MODE_STD;
                  else                  cmd_fault <= 1'b1;
               end
               default: cmd_fault <= 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/trg_access_judge.sv
`timescale 1ns/1ps
module trg_access_judge
   import trg_pkg::*;
#(
   parameter int NREG = 5
) (
   input  logic [NREG-1:0] hit_vec,
   input  mode_e           mode,
   input  logic            is_write,
   output logic [2:0]      region,
   output logic            grant,
   output logic            integ,
   output logic            crypt
);
   always_comb begin
      region = RG_NONE;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (hit_vec[i]) region = 3'(i);
      end
   end

   logic allowed;
   always_comb begin
      if (region == RG_NONE)            allowed = 1'b0;
      else if (is_write && rg_is_static(region)) allowed = 1'b0;
      else if (mode == MODE_SEC)        allowed = 1'b1;
      else                              allowed = (region == RG_OPEN);
   end

   assign grant = allowed;
   assign integ = allowed && rg_is_verified(region);
   assign crypt = allowed && rg_is_encrypted(region);
endmodule

// File: rtl/trust_region_guard.sv
`timescale 1ns/1ps
module trust_region_guard
   import trg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              hash_done_i,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_sel_i,
   input  logic [ADDR_W-1:0] cfg_base_i,
   input  logic [ADDR_W-1:0] cfg_limit_i,
   input  logic              acc_valid_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic              acc_write_i,
   output logic [1:0]        mode_o,
   output logic              busy_o,
   output logic              cmd_fault_o,
   output logic              acc_done_o,
   output logic              acc_grant_o,
   output logic              acc_fault_o,
   output logic              acc_integ_o,
   output logic              acc_crypt_o,
   output logic [2:0]        acc_region_o
);
   localparam int SEL_W = 3;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("trust_region_guard: ADDR_W must be at least 4");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("trust_region_guard: PC_W must be at least 2");
   end

   mode_e             mode;
   logic [NUM_REGIONS-1:0] hit_vec;
   logic              cfg_take;
   logic [2:0]        j_region;
   logic              j_grant, j_integ, j_crypt;

   trg_mode_fsm #(.PC_W(PC_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid_i),
      .cmd_op    (cmd_op_i),
      .pc        (pc_i),
      .hash_done (hash_done_i),
      .mode      (mode),
      .busy      (busy_o),
      .cmd_fault (cmd_fault_o)
   );

   assign cfg_take = cfg_we_i && (mode == MODE_SEC) && (cfg_sel_i < SEL_W'(NUM_REGIONS));

   trg_region_bank #(.ADDR_W(ADDR_W), .NREG(NUM_REGIONS), .SEL_W(SEL_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_take),
      .wr_sel     (cfg_sel_i),
      .wr_base    (cfg_base_i),
      .wr_limit   (cfg_limit_i),
      .probe_addr (acc_addr_i),
      .hit_vec    (hit_vec)
   );

   trg_access_judge #(.NREG(NUM_REGIONS)) u_judge (
      .hit_vec  (hit_vec),
      .mode     (mode),
      .is_write (acc_write_i),
      .region   (j_region),
      .grant    (j_grant),
      .integ    (j_integ),
      .crypt    (j_crypt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_done_o   <= 1'b0;
         acc_grant_o  <= 1'b0;
         acc_fault_o  <= 1'b0;
         acc_integ_o  <= 1'b0;
         acc_crypt_o  <= 1'b0;
         acc_region_o <= RG_NONE;
      end else begin
         acc_done_o   <= acc_valid_i;
         acc_grant_o  <= acc_valid_i && j_grant;
         acc_fault_o  <= acc_valid_i && !j_grant;
         acc_integ_o  <= acc_valid_i && j_integ;
         acc_crypt_o  <= acc_valid_i && j_crypt;
         acc_region_o <= acc_valid_i ? j_region : RG_NONE;
      end
   end

   assign mode_o = mode;
endmodule

// File: rtl/trg_checker.sv
`timescale 1ns/1ps
module trg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid_i,
   input logic [1:0] cmd_op_i,
   input logic       hash_done_i,
   input logic       acc_write_i,
   input logic [1:0] mode_o,
   input logic       busy_o,
   input logic       acc_done_o,
   input logic       acc_grant_o,
   input logic       acc_fault_o,
   input logic       acc_integ_o,
   input logic       acc_crypt_o,
   input logic [2:0] acc_region_o
);
   // R1
   mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'd3);

   // R2
   enter_via_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 2'd0 && mode_o == 2'd1) |-> $past(hash_done_i && busy_o));

   // R4
   suspend_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 2'd1 && mode_o == 2'd2) |-> $past(cmd_valid_i && cmd_op_i == 2'd1));

   // R5
   resume_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == 2'd2 && mode_o == 2'd1) |-> $past(cmd_valid_i && cmd_op_i == 2'd2));

   // R9
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done_o |-> (acc_grant_o ^ acc_fault_o));

   // R9
   idle_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_done_o |-> (!acc_grant_o && !acc_fault_o));

   // R8
   crypt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_crypt_o |-> (acc_integ_o && acc_grant_o));

   // R6
   static_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done_o && $past(acc_write_i) && acc_region_o <= 3'd1) |-> acc_fault_o);

   // R7
   untrusted_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done_o && acc_grant_o && $past(mode_o) != 2'd1) |-> acc_region_o == 3'd4);

   // R10
   miss_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done_o && acc_region_o == 3'd7) |-> acc_fault_o);
endmodule

bind trust_region_guard trg_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid_i  (cmd_valid_i),
   .cmd_op_i     (cmd_op_i),
   .hash_done_i  (hash_done_i),
   .acc_write_i  (acc_write_i),
   .mode_o       (mode_o),
   .busy_o       (busy_o),
   .acc_done_o   (acc_done_o),
   .acc_grant_o  (acc_grant_o),
   .acc_fault_o  (acc_fault_o),
   .acc_integ_o  (acc_integ_o),
   .acc_crypt_o  (acc_crypt_o),
   .acc_region_o (acc_region_o)
);

// File: tb/trust_region_guard_test.sv
`timescale 1ns/1ps
module trust_region_guard_test;
   localparam int AW = 32;
   localparam int PW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid_i = 0; logic [1:0] cmd_op_i = 0; logic [PW-1:0] pc_i = 0;
   logic hash_done_i = 0;
   logic cfg_we_i = 0; logic [2:0] cfg_sel_i = 0;
   logic [AW-1:0] cfg_base_i = 0, cfg_limit_i = 0;
   logic acc_valid_i = 0; logic [AW-1:0] acc_addr_i = 0; logic acc_write_i = 0;
   logic [1:0] mode_o; logic busy_o, cmd_fault_o, acc_done_o, acc_grant_o;
   logic acc_fault_o, acc_integ_o, acc_crypt_o; logic [2:0] acc_region_o;

   always #2 clk = ~clk;

   trust_region_guard #(.ADDR_W(AW), .PC_W(PW)) uut (.*);

   int checks = 0, fails = 0;
   bit finished = 0;

   // bench model state
   logic [1:0]    m_mode;
   bit            m_busy;
   logic [PW-1:0] m_resume;
   logic [AW-1:0] m_lo [5];
   logic [AW-1:0] m_hi [5];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = 0; m_busy = 0; m_resume = 0;
      for (int i = 0; i < 5; i++) begin m_lo[i] = '1; m_hi[i] = '0; end
   endtask

   function automatic logic [2:0] pick_region(input logic [AW-1:0] a);
      for (int i = 0; i < 5; i++)
         if (a >= m_lo[i] && a <= m_hi[i]) return 3'(i);
      return 3'd7;
   endfunction

   task automatic step(input bit cv, input logic [1:0] op, input logic [PW-1:0] pc,
                       input bit hd, input bit cw, input logic [2:0] cs,
                       input logic [AW-1:0] cb, input logic [AW-1:0] cl,
                       input bit av, input logic [AW-1:0] aa, input bit aw);
      logic [1:0] e_mode; bit e_busy, e_cf, e_gr, e_in, e_cr; logic [2:0] e_rg;
      @(negedge clk);
      cmd_valid_i = cv; cmd_op_i = op; pc_i = pc; hash_done_i = hd;
      cfg_we_i = cw; cfg_sel_i = cs; cfg_base_i = cb; cfg_limit_i = cl;
      acc_valid_i = av; acc_addr_i = aa; acc_write_i = aw;
      // access verdict on pre-edge state (R6 R7 R8 R10)
      e_rg = av ? pick_region(aa) : 3'd7;
      e_gr = av && e_rg != 3'd7 && !(aw && e_rg <= 3'd1) && (m_mode == 2'd1 || e_rg == 3'd4);
      e_in = e_gr && e_rg <= 3'd3;
      e_cr = e_gr && (e_rg == 3'd1 || e_rg == 3'd3);
      // configuration (R11)
      if (cw && m_mode == 2'd1 && cs <= 3'd4) begin m_lo[cs] = cb; m_hi[cs] = cl; end
      // mode commands (R2 R3 R4 R5)
      e_cf = 0;
      if (m_busy) begin
         if (hd) begin m_mode = 2'd1; m_busy = 0; end
      end else if (cv) begin
         case (op)
            2'd0: if (m_mode == 2'd0) m_busy = 1; else e_cf = 1;
            2'd1: if (m_mode == 2'd1) begin m_mode = 2'd2; m_resume = pc; end else e_cf = 1;
            2'd2: if (m_mode == 2'd2 && pc == m_resume) m_mode = 2'd1; else e_cf = 1;
            default: if (m_mode != 2'd0) m_mode = 2'd0; else e_cf = 1;
         endcase
      end
      e_mode = m_mode; e_busy = m_busy;
      @(posedge clk); #1;
      chk(mode_o == e_mode, "R2 R3 R4 R5 mode", mode_o, e_mode);
      chk(busy_o == e_busy, "R2 busy", busy_o, e_busy);
      chk(cmd_fault_o == e_cf, "R2 R3 R4 R5 cmd_fault", cmd_fault_o, e_cf);
      chk(acc_done_o == av, "R9 done", acc_done_o, av);
      chk(acc_grant_o == e_gr, "R6 R7 R11 grant", acc_grant_o, e_gr);
      chk(acc_fault_o == (av && !e_gr), "R9 fault", acc_fault_o, av && !e_gr);
      chk(acc_integ_o == e_in, "R8 integ", acc_integ_o, e_in);
      chk(acc_crypt_o == e_cr, "R8 crypt", acc_crypt_o, e_cr);
      chk(acc_region_o == e_rg, "R10 region", acc_region_o, e_rg);
   endtask

   task automatic acc(input logic [AW-1:0] a, input bit w);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, a, w);
   endtask
   task automatic cmd(input logic [1:0] op, input logic [PW-1:0] pc, input bit hd);
      step(1, op, pc, hd, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic cfg(input logic [2:0] s, input logic [AW-1:0] b, input logic [AW-1:0] l);
      step(0, 0, 0, 0, 1, s, b, l, 0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'h1234_5a5a;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      chk(mode_o == 0 && busy_o == 0 && acc_done_o == 0, "R1 reset", mode_o, 0);
      acc(10, 0);                             // R1 empty regions miss
      cfg(4, 0, 255);                         // R11 ignored in standard mode
      acc(10, 0);
      cmd(0, 0, 0);                           // R2 enter
      cmd(1, 32'h100, 0);                     // R2 ignored while busy
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cmd(3, 0, 1);                           // R2 hash done, exit ignored
      cmd(0, 0, 0);                           // R2 enter in secure faults
      cfg(0, 0, 15); cfg(1, 16, 31); cfg(2, 32, 63); cfg(3, 48, 79); cfg(4, 0, 255);
      cfg(6, 0, 1000);                        // R11 bad select ignored
      acc(5, 1);                              // R6 static write
      acc(20, 1);                             // R6
      acc(20, 0);                             // R8 integ+crypt
      acc(50, 1);                             // R10 overlap picks 2
      acc(70, 0);                             // R8 region 3
      acc(300, 0);                            // R10 miss
      cmd(1, 32'h104, 0);                     // R4 suspend
      acc(5, 0);                              // R7 protected locked
      acc(200, 1);                            // R7 open ok
      cfg(4, 0, 0);                           // R11 ignored in suspended
      acc(200, 0);
      cmd(2, 32'h108, 0);                     // R5 wrong pc
      cmd(2, 32'h104, 0);                     // R5 correct pc
      cmd(2, 32'h104, 0);                     // R5 resume in secure faults
      cmd(3, 0, 0);                           // R3 exit
      cmd(3, 0, 0);                           // R3 exit in standard faults
      cmd(1, 0, 0);                           // R4 suspend in standard faults
      for (int n = 0; n < 4000; n++) begin
         logic [AW-1:0] b;
         b = AW'($urandom_range(0, 200));
         step($urandom_range(0, 9) < 3, 2'($urandom_range(0, 3)),
              PW'(32'h100 + 4 * $urandom_range(0, 2)), $urandom_range(0, 9) < 3,
              $urandom_range(0, 9) < 2, 3'($urandom_range(0, 7)),
              b, b + AW'($urandom_range(0, 80)),
              $urandom_range(0, 9) < 7, AW'($urandom_range(0, 300)), $urandom_range(0, 1) == 1);
      end
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule